// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Zero Suppression Chain

This block turns one 4-bit BCD digit into the seven segment drives of a display digit. All drives are active-LOW: a segment that should glow is driven to 0. Three control inputs act on the result. A forced-blank input darkens the digit. A lamp-test input lights every segment so the display can be inspected. A ripple-blank input, together with a zero digit, makes the digit go dark instead of showing "0".

A ripple-blank output reports that the digit was darkened for exactly that reason. Several identical copies can be chained so that zeros are suppressed across a multi-digit number. For leading zeros, the most significant digit has its ripple-blank input held active. Each digit's ripple-blank output drives the ripple-blank input of the next lower digit. The least significant digit has its ripple-blank input held inactive, so a value of zero still shows one "0".

The block is purely combinational. The forced-blank input and the ripple-blank output are separate ports rather than one shared wired pin.

Top module: `bcd_seg_decoder`

## Requirements
- R1: Segment drives are active-LOW. Bit 0 of `segN` drives segment a, and bits 1 through 6 drive segments b, c, d, e, f and g in that order.
- R2: With `blankInN`, `lampTestN` and `rippleInN` all high, digits 0 to 9 light these segments (listed as the set of lit segments): 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 abcdefg, 9 abcdfg.
- R3: When `blankInN` is low, `segN` is 7'b1111111 and `rippleOutN` is high, whatever the BCD code, lamp test or ripple-blank input.
- R4: When `blankInN` is high and `lampTestN` is low, `segN` is 7'b0000000, whatever the BCD code or ripple-blank input.
- R5: When `blankInN` and `lampTestN` are high, `rippleInN` is low and the BCD code is 0, `segN` is 7'b1111111 and `rippleOutN` is low.
- R6: When `rippleInN` is high and there is no override, a BCD code of 0 shows "0" and `rippleOutN` stays high.
- R7: BCD codes 10 to 15 with no override give `segN` = 7'b1111111, and `rippleOutN` stays high even when `rippleInN` is low.
- R8: `rippleOutN` is low only in the case of R5. A nonzero digit with `rippleInN` low is decoded normally.
- R9: In a chain of decoders wired for leading-zero suppression, a digit is dark exactly when it and every more significant digit are zero, and it is not the least significant digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bcdIn | input | 4 | BCD digit to display |
| lampTestN | input | 1 | Lamp test, active-LOW, lights all segments |
| blankInN | input | 1 | Forced blank, active-LOW, highest priority |
| rippleInN | input | 1 | Ripple-blank input, active-LOW, darkens a zero digit |
| segN | output | 7 | Segment drives a..g on bits 0..6, active-LOW |
| rippleOutN | output | 1 | Ripple-blank output, active-LOW, low when a zero was suppressed |

## Verification
The hardest case to reach is suppression propagating through a chain. A digit is darkened only when every more significant digit is zero, and the outcome depends on the ripple output of one instance reaching the next. The bench builds a four-digit chain of the block and applies multi-digit values with zeros in different places: all zeros, a zero run broken by a nonzero digit, and zeros only below a nonzero digit. It compares every digit against a suppression model worked out from the value itself. A single-digit sweep of every combination of code and controls covers the priority order.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_N   = 7;
  localparam int DIGIT_MAX = 9;

  // strobes from the control path to the segment datapath
  typedef struct packed {
    logic darkAll;   // drive every segment off
    logic lampAll;   // drive every segment on
  } segCtrl_t;
endpackage

// File: rtl/bcd_seg_ctrl.sv
module bcd_seg_ctrl
  import bcd_seg_pkg::*;
(
  input  logic [DIGIT_W-1:0] bcdIn,
  input  logic               lampTestN,
  input  logic               blankInN,
  input  logic               rippleInN,
  output segCtrl_t           ctrl,
  output logic               rippleOutN
);
  logic isZero;
  logic zeroSuppress;

  always_comb begin
    isZero       = (bcdIn == '0);
    // priority: forced blank, then lamp test, then ripple blank
    zeroSuppress = blankInN && lampTestN && !rippleInN && isZero;
    ctrl.darkAll = !blankInN || zeroSuppress;
    ctrl.lampAll = blankInN && !lampTestN;
    rippleOutN   = !zeroSuppress;
  end
endmodule

// File: rtl/bcd_seg_path.sv
module bcd_seg_path
  import bcd_seg_pkg::*;
(
  input  logic [DIGIT_W-1:0] bcdIn,
  input  segCtrl_t           ctrl,
  output logic [SEG_N-1:0]   segN
);
  logic [SEG_N-1:0] litMask;   // 1 = segment glows, bit0 = a
  logic [SEG_N-1:0] litFinal;

  always_comb begin
    unique case (bcdIn)
      4'd0:    litMask = 7'b0111111;
      4'd1:    litMask = 7'b0000110;
      4'd2:    litMask = 7'b1011011;
      4'd3:    litMask = 7'b1001111;
      4'd4:    litMask = 7'b1100110;
      4'd5:    litMask = 7'b1101101;
      4'd6:    litMask = 7'b1111101;
      4'd7:    litMask = 7'b0000111;
      4'd8:    litMask = 7'b1111111;
      4'd9:    litMask = 7'b1101111;
      default: litMask = '0;   // codes above nine stay dark
    endcase
    if (ctrl.darkAll)      litFinal = '0;
    else if (ctrl.lampAll) litFinal = '1;
    else                   litFinal = litMask;
  end

  // per-segment active-LOW output stage
  for (genvar s = 0; s < SEG_N; s++) begin : gDrive
    assign segN[s] = ~litFinal[s];
  end
endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import bcd_seg_pkg::*;
(
  input  logic [3:0] bcdIn,
  input  logic       lampTestN,
  input  logic       blankInN,
  input  logic       rippleInN,
  output logic [6:0] segN,
  output logic       rippleOutN
);
  segCtrl_t ctrl;

  bcd_seg_ctrl uCtrl (
    .bcdIn(bcdIn), .lampTestN(lampTestN), .blankInN(blankInN),
    .rippleInN(rippleInN), .ctrl(ctrl), .rippleOutN(rippleOutN)
  );

  bcd_seg_path uPath (
    .bcdIn(bcdIn), .ctrl(ctrl), .segN(segN)
  );
endmodule

// File: rtl/bcd_seg_checker.sv
module bcd_seg_checker (
  input logic [3:0] bcdIn,
  input logic       lampTestN,
  input logic       blankInN,
  input logic       rippleInN,
  input logic [6:0] segN,
  input logic       rippleOutN
);
  always_comb begin
    if (!blankInN) begin
      assert_blank_dark_R3: assert (segN == 7'h7F && rippleOutN);
    end
    if (blankInN && !lampTestN) begin
      assert_lamp_all_R4: assert (segN == 7'h00);
    end
    if (!rippleOutN) begin
      assert_ripple_cause_R8: assert (bcdIn == 4'd0 && !rippleInN && blankInN && lampTestN);
    end
    if (!rippleOutN) begin
      assert_ripple_dark_R5: assert (segN == 7'h7F);
    end
    if (blankInN && lampTestN && bcdIn > 4'd9) begin
      assert_invalid_dark_R7: assert (segN == 7'h7F && rippleOutN);
    end
    if (blankInN && lampTestN && rippleInN && bcdIn == 4'd0) begin
      assert_zero_shown_R6: assert (segN == 7'b1000000 && rippleOutN);
    end
  end
endmodule

bind bcd_seg_decoder bcd_seg_checker uChk (
  .bcdIn(bcdIn), .lampTestN(lampTestN), .blankInN(blankInN),
  .rippleInN(rippleInN), .segN(segN), .rippleOutN(rippleOutN)
);

// File: tb/sim_bcd_seg_decoder.sv
module sim_bcd_seg_decoder;
  logic clk = 0;
  logic rstN = 0;
  always #2 clk = ~clk;   // 250 MHz

  int nRun = 0, nFail = 0;
  int cycles = 0;

  logic [3:0] bcdIn = 0;
  logic lampTestN = 1, blankInN = 0, rippleInN = 1;
  logic [6:0] segN;
  logic rippleOutN;

  bcd_seg_decoder u0 (
    .bcdIn(bcdIn), .lampTestN(lampTestN), .blankInN(blankInN),
    .rippleInN(rippleInN), .segN(segN), .rippleOutN(rippleOutN)
  );

  // four-digit chain, index 3 most significant
  logic [3:0] chDig [4];
  logic [6:0] chSeg [4];
  logic       chRbo [4];
  logic       chRbi [4];
  assign chRbi[3] = 1'b0;
  assign chRbi[2] = chRbo[3];
  assign chRbi[1] = chRbo[2];
  assign chRbi[0] = 1'b1;
  for (genvar i = 0; i < 4; i++) begin : gChain
    bcd_seg_decoder uD (
      .bcdIn(chDig[i]), .lampTestN(1'b1), .blankInN(1'b1),
      .rippleInN(chRbi[i]), .segN(chSeg[i]), .rippleOutN(chRbo[i])
    );
  end
  initial for (int i = 0; i < 4; i++) chDig[i] = 0;

  // reference: lit-segment strings, letter order abcdefg
  function automatic logic [6:0] litOf(input string s);
    logic [6:0] m = 0;
    for (int k = 0; k < s.len(); k++) m[s[k] - "a"] = 1'b1;
    return m;
  endfunction

  function automatic logic [6:0] digitSeg(input int d);
    string t[10] = '{"abcdef","bc","abdeg","abcdg","bcfg","acdfg","acdefg","abc","abcdefg","abcdfg"};
    if (d > 9) return 7'h7F;
    return ~litOf(t[d]);
  endfunction

  function automatic void refModel(input int d, input bit lt, input bit bi, input bit rbi,
                                   output logic [6:0] s, output logic r);
    r = 1;
    if (!bi) s = 7'h7F;
    else if (!lt) s = 7'h00;
    else if (!rbi && d == 0) begin s = 7'h7F; r = 0; end
    else s = digitSeg(d);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input int d, input bit lt, input bit bi, input bit rbi);
    @(negedge clk);
    bcdIn = d[3:0]; lampTestN = lt; blankInN = bi; rippleInN = rbi;
    @(posedge clk); #1;
  endtask

  task automatic expectOne(input string tag, input int d, input bit lt, input bit bi, input bit rbi);
    logic [6:0] s; logic r;
    apply(d, lt, bi, rbi);
    refModel(d, lt, bi, rbi, s, r);
    check(tag, {rippleOutN, segN}, {r, s});
  endtask

  task automatic chainValue(input int v);
    logic [6:0] s; bit dark; bit zeroAbove;
    @(negedge clk);
    for (int i = 0; i < 4; i++) chDig[i] = 4'((v / (10 ** i)) % 10);
    @(posedge clk); #1;
    zeroAbove = 1;
    for (int i = 3; i >= 0; i--) begin
      int d = (v / (10 ** i)) % 10;
      zeroAbove = zeroAbove && (d == 0);
      dark = zeroAbove && (i != 0);
      s = dark ? 7'h7F : digitSeg(d);
      check($sformatf("R9 chain value %0d digit %0d", v, i), {1'b0, chSeg[i]}, {1'b0, s});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1;
    #1;
    // reset state: forced blank held, all dark
    check("R3 reset dark", {rippleOutN, segN}, 8'hFF);
    // R1 bit positions: digit 1 lights only b and c -> bits 1,2 low
    apply(1, 1, 1, 1);
    check("R1 digit1 bits", {1'b0, segN}, {1'b0, 7'b1111001});
    // R2 all digits plain
    for (int d = 0; d < 10; d++) expectOne($sformatf("R2 digit %0d", d), d, 1, 1, 1);
    expectOne("R3 blank over lamp", 8, 0, 0, 0);
    expectOne("R4 lamp on invalid", 13, 0, 1, 0);
    expectOne("R4 lamp on zero rbi", 0, 0, 1, 0);
    expectOne("R5 ripple zero", 0, 1, 1, 0);
    apply(0, 1, 1, 0);
    check("R5 rbo low", {7'b0, rippleOutN}, 8'h00);
    expectOne("R6 zero shown", 0, 1, 1, 1);
    for (int d = 10; d < 16; d++) expectOne($sformatf("R7 code %0d", d), d, 1, 1, 0);
    expectOne("R8 nonzero with rbi", 7, 1, 1, 0);
    // full sweep of code and controls
    for (int k = 0; k < 128; k++)
      expectOne($sformatf("R8 sweep %0d", k), k & 15, k[4], k[5], k[6]);
    chainValue(0);
    chainValue(70);
    chainValue(1000);
    chainValue(5);
    chainValue(3040);
    chainValue(9999);
    chainValue(102);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule